// File: doc/BRIEF.md
# Four-Stage Configurable Pipeline Register Bank

This block holds four data registers, called stage 1 to stage 4, that all update on the rising clock edge. A 2-bit operation code picks how the bank loads on each edge. It can run all four stages as a single delay line, or it can treat the bank as two separate two-stage pairs, stages 1–2 and stages 3–4. It can also freeze every stage. A 2-bit read select drives a 4-to-1 multiplexer that places one stage on the output bus. Writing and reading are controlled separately, so one stage can be loaded in the same cycle that another is read.

The parameter `PAIR_HOLD` picks one of two variants. They differ only in what the downstream stage of a pair does when the pair's upstream stage takes new input data. With `PAIR_HOLD = 0` the downstream stage shifts and takes the old upstream value. With `PAIR_HOLD = 1` the downstream stage keeps its contents. The three-state output is modelled as a data bus plus a drive-enable flag. An active-low output enable controls both. An optional synchronous reset clears the bank.

Top module: `pipereg_quad`

## Requirements
- R1: While `srst` is high at a rising edge, all four stages become zero, whatever `op` is.
- R2: `op = 2'b00` shifts the whole bank on one edge: `din` goes to stage 1, and stage 1 goes to stage 2, stage 2 to stage 3 and stage 3 to stage 4. Each move uses the value the stage held before the edge.
- R3: `op = 2'b11` leaves all four stages unchanged, whatever `din` is.
- R4: With `PAIR_HOLD = 0`, `op = 2'b10` loads `din` into stage 1 and moves the old stage 1 into stage 2. Stages 3 and 4 hold.
- R5: With `PAIR_HOLD = 0`, `op = 2'b01` loads `din` into stage 3 and moves the old stage 3 into stage 4. Stages 1 and 2 hold.
- R6: With `PAIR_HOLD = 1`, `op = 2'b10` loads `din` into stage 1 only. Stages 2, 3 and 4 hold.
- R7: With `PAIR_HOLD = 1`, `op = 2'b01` loads `din` into stage 3 only. Stages 1, 2 and 4 hold.
- R8: Read select `rsel` picks the stage shown on `y` as follows: `2'b00` gives stage 4, `2'b01` gives stage 3, `2'b10` gives stage 2 and `2'b11` gives stage 1. The path is combinational, so a stage written at an edge appears on `y` right after that edge.
- R9: While `oe_n` is high, `y_en` is 0 and `y` is all zeros. While `oe_n` is low, `y_en` is 1.
- R10: A stage can be read while a different stage is being loaded in the same cycle. The value read is the contents from before the edge, and no data passes through more than one stage per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Load operation code |
| rsel | input | 2 | Read stage select |
| din | input | DATA_W | Input data |
| oe_n | input | 1 | Output enable, active low |
| y | output | DATA_W | Selected stage data, zero when not driven |
| y_en | output | 1 | High when the output bus would be driven |

## Verification
The hardest case to reach is a pair operation where the downstream stage's behaviour depends on the variant. Stage 2 or stage 4 only shows a difference if its upstream stage already holds a value different from its own. The bench therefore first fills the bank with four distinct values using full shifts. It then runs the same pair operations on two instances, one of each variant, and reads every stage back through the multiplexer after each edge. Reads are also performed through `rsel` in the same cycle a load is set up, to show the read returns the contents from before the edge.

// File: rtl/pipereg_pkg.sv
package pipereg_pkg;

   localparam int unsigned NSTAGE = 4;

   typedef enum logic [1:0] {
      OP_SHIFT_ALL = 2'b00,
      OP_LOAD_LOW  = 2'b01,
      OP_LOAD_HIGH = 2'b10,
      OP_FREEZE    = 2'b11
   } pipe_op_e;

   // stage index shown for each read select value
   function automatic int unsigned rsel_to_stage(input logic [1:0] s);
      return NSTAGE - 1 - int'(s);
   endfunction

endpackage

// File: rtl/pipereg_ctrl.sv
module pipereg_ctrl
   import pipereg_pkg::*;
#(
   parameter int unsigned PAIR_HOLD = 0
) (
   input  logic [1:0]        op,
   output logic [NSTAGE-1:0] ld_en,
   output logic              s3_from_din
);

   pipe_op_e op_e;
   assign op_e = pipe_op_e'(op);

   if (PAIR_HOLD > 1) begin : g_bad_variant
      $error("pipereg_ctrl: PAIR_HOLD must be 0 or 1");
   end

   if (PAIR_HOLD == 0) begin : g_pair_shift
      always_comb begin
         ld_en       = '0;
         s3_from_din = 1'b0;
         unique case (op_e)
            OP_SHIFT_ALL: ld_en = 4'b1111;
            OP_LOAD_LOW: begin
               ld_en       = 4'b1100;
               s3_from_din = 1'b1;
            end
            OP_LOAD_HIGH: ld_en = 4'b0011;
            OP_FREEZE:    ld_en = 4'b0000;
            default:      ld_en = 4'b0000;
         endcase
      end
   end else begin : g_pair_hold
      always_comb begin
         ld_en       = '0;
         s3_from_din = 1'b0;
         unique case (op_e)
            OP_SHIFT_ALL: ld_en = 4'b1111;
            OP_LOAD_LOW: begin
               ld_en       = 4'b0100;
               s3_from_din = 1'b1;
            end
            OP_LOAD_HIGH: ld_en = 4'b0001;
            OP_FREEZE:    ld_en = 4'b0000;
            default:      ld_en = 4'b0000;
         endcase
      end
   end

   // R3: freeze never enables a stage
   always_comb begin
      if (op_e == OP_FREEZE) p_freeze_no_en_r3: assert (ld_en == '0);
   end

endmodule

// File: rtl/pipereg_bank.sv
module pipereg_bank
   import pipereg_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          HAS_SRST = 1'b1
) (
   input  logic                          clk,
   input  logic                          srst,
   input  logic [NSTAGE-1:0]             ld_en,
   input  logic                          s3_from_din,
   input  logic [DATA_W-1:0]             din,
   output logic [NSTAGE-1:0][DATA_W-1:0] q
);

   if (DATA_W < 1) begin : g_bad_width
      $error("pipereg_bank: DATA_W must be at least 1");
   end

   logic [NSTAGE-1:0][DATA_W-1:0] nxt;

   for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign nxt[k] = din;
      end else if (k == 2) begin : g_pair_head
         assign nxt[k] = s3_from_din ? din : q[k-1];
      end else begin : g_follow
         assign nxt[k] = q[k-1];
      end

      if (HAS_SRST) begin : g_rst
         always_ff @(posedge clk) begin
            if (srst)          q[k] <= '0;
            else if (ld_en[k]) q[k] <= nxt[k];
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (ld_en[k]) q[k] <= nxt[k];
         end
      end
   end

   // R10: a stage without enable keeps its value
   p_idle_stable_r10: assert property (@(posedge clk) disable iff (srst)
      (ld_en == '0) |=> $stable(q));

   // R2: the head stage always takes din when enabled
   p_head_load_r2: assert property (@(posedge clk) disable iff (srst)
      ld_en[0] |=> (q[0] == $past(din)));

endmodule

// File: rtl/pipereg_rdmux.sv
module pipereg_rdmux
   import pipereg_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [NSTAGE-1:0][DATA_W-1:0] q,
   input  logic [1:0]                    rsel,
   input  logic                          oe_n,
   output logic [DATA_W-1:0]             y,
   output logic                          y_en
);

   logic [DATA_W-1:0] picked;

   always_comb begin
      unique case (rsel)
         2'b00:   picked = q[3];
         2'b01:   picked = q[2];
         2'b10:   picked = q[1];
         default: picked = q[0];
      endcase
   end

   assign y_en = ~oe_n;
   assign y    = oe_n ? '0 : picked;

   // R9: a disabled bus carries no data
   always_comb begin
      if (oe_n) p_quiet_bus_r9: assert (y == '0 && !y_en);
   end

endmodule

// File: rtl/pipereg_quad.sv
module pipereg_quad
   import pipereg_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned PAIR_HOLD = 0,
   parameter bit          HAS_SRST  = 1'b1
) (
   input  logic              clk,
   input  logic              srst,
   input  logic [1:0]        op,
   input  logic [1:0]        rsel,
   input  logic [DATA_W-1:0] din,
   input  logic              oe_n,
   output logic [DATA_W-1:0] y,
   output logic              y_en
);

   logic [NSTAGE-1:0]             ld_en;
   logic                          s3_from_din;
   logic [NSTAGE-1:0][DATA_W-1:0] q;

   pipereg_ctrl #(.PAIR_HOLD(PAIR_HOLD)) u_ctrl (
      .op          (op),
      .ld_en       (ld_en),
      .s3_from_din (s3_from_din)
   );

   pipereg_bank #(.DATA_W(DATA_W), .HAS_SRST(HAS_SRST)) u_bank (
      .clk         (clk),
      .srst        (srst),
      .ld_en       (ld_en),
      .s3_from_din (s3_from_din),
      .din         (din),
      .q           (q)
   );

   pipereg_rdmux #(.DATA_W(DATA_W)) u_rdmux (
      .q    (q),
      .rsel (rsel),
      .oe_n (oe_n),
      .y    (y),
      .y_en (y_en)
   );

   // R2: full shift moves every stage by exactly one
   p_shift_all_r2: assert property (@(posedge clk) disable iff (srst)
      (op == 2'b00) |=> (q[0] == $past(din) && q[1] == $past(q[0]) &&
                         q[2] == $past(q[1]) && q[3] == $past(q[2])));

   // R3: freeze keeps the whole bank
   p_freeze_r3: assert property (@(posedge clk) disable iff (srst)
      (op == 2'b11) |=> $stable(q));

   // R8: enabled bus shows the selected stage
   p_select_r8: assert property (@(posedge clk) disable iff (srst)
      (!oe_n) |-> (y == q[rsel_to_stage(rsel)]));

   if (HAS_SRST) begin : g_rst_chk
      // R1: reset clears the bank
      p_reset_r1: assert property (@(posedge clk)
         srst |=> (q == '0));
   end

   if (PAIR_HOLD == 0) begin : g_chk_shift
      // R4
      p_high_pair_r4: assert property (@(posedge clk) disable iff (srst)
         (op == 2'b10) |=> (q[0] == $past(din) && q[1] == $past(q[0]) &&
                            q[2] == $past(q[2]) && q[3] == $past(q[3])));
      // R5
      p_low_pair_r5: assert property (@(posedge clk) disable iff (srst)
         (op == 2'b01) |=> (q[2] == $past(din) && q[3] == $past(q[2]) &&
                            q[0] == $past(q[0]) && q[1] == $past(q[1])));
   end else begin : g_chk_hold
      // R6
      p_high_only_r6: assert property (@(posedge clk) disable iff (srst)
         (op == 2'b10) |=> (q[0] == $past(din) && q[1] == $past(q[1]) &&
                            q[2] == $past(q[2]) && q[3] == $past(q[3])));
      // R7
      p_low_only_r7: assert property (@(posedge clk) disable iff (srst)
         (op == 2'b01) |=> (q[2] == $past(din) && q[0] == $past(q[0]) &&
                            q[1] == $past(q[1]) && q[3] == $past(q[3])));
   end

endmodule

// File: tb/tb_pipereg_quad.sv
`timescale 1ns/100ps
module tb_pipereg_quad;

   logic       clk = 1'b0;
   logic       srst;
   logic [1:0] op;
   logic [1:0] rsel;
   logic [7:0] din;
   logic       oe_n;
   logic [7:0] y_s, y_h;
   logic       en_s, en_h;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] ms [4];
   logic [7:0] mh [4];

   always #4 clk = ~clk;

   pipereg_quad #(.DATA_W(8), .PAIR_HOLD(0)) dut (
      .clk(clk), .srst(srst), .op(op), .rsel(rsel), .din(din),
      .oe_n(oe_n), .y(y_s), .y_en(en_s));

   pipereg_quad #(.DATA_W(8), .PAIR_HOLD(1)) dut_hold (
      .clk(clk), .srst(srst), .op(op), .rsel(rsel), .din(din),
      .oe_n(oe_n), .y(y_h), .y_en(en_h));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // expected behaviour of both variants per R1..R7
   task automatic model(input logic rst, input logic [1:0] o, input logic [7:0] d);
      logic [7:0] s [4];
      logic [7:0] h [4];
      s = ms; h = mh;
      if (rst) begin
         for (int k = 0; k < 4; k++) begin s[k] = 8'h00; h[k] = 8'h00; end
      end else begin
         case (o)
            2'b00: begin
               s[0] = d; s[1] = ms[0]; s[2] = ms[1]; s[3] = ms[2];
               h[0] = d; h[1] = mh[0]; h[2] = mh[1]; h[3] = mh[2];
            end
            2'b10: begin s[0] = d; s[1] = ms[0]; h[0] = d; end
            2'b01: begin s[2] = d; s[3] = ms[2]; h[2] = d; end
            default: ;
         endcase
      end
      ms = s; mh = h;
   endtask

   task automatic step(input logic rst, input logic [1:0] o, input logic [7:0] d);
      @(negedge clk);
      srst = rst; op = o; din = d;
      @(posedge clk);
      model(rst, o, d);
      @(negedge clk);
      srst = 1'b0; op = 2'b11;
   endtask

   // read every stage through rsel (R8): rsel 0..3 -> stage 4..1
   task automatic read_all(input string req);
      for (int s = 0; s < 4; s++) begin
         rsel = s[1:0];
         #0.5;
         chk(req, y_s, ms[3-s]);
         chk(req, y_h, mh[3-s]);
      end
   endtask

   task automatic t_reset;
      step(1'b1, 2'b00, 8'hAA);
      read_all("R1 reset clear");
   endtask

   task automatic t_shift;
      step(1'b0, 2'b00, 8'h11); read_all("R2 shift 1");
      step(1'b0, 2'b00, 8'h22); read_all("R2 shift 2");
      step(1'b0, 2'b00, 8'h33);
      step(1'b0, 2'b00, 8'h44); read_all("R2/R10 shift full");
   endtask

   task automatic t_freeze;
      step(1'b0, 2'b11, 8'hFF); read_all("R3 freeze");
      step(1'b0, 2'b11, 8'h5A); read_all("R3 freeze 2");
   endtask

   task automatic t_pairs;
      step(1'b0, 2'b10, 8'hA1); read_all("R4/R6 high pair");
      step(1'b0, 2'b01, 8'hB2); read_all("R5/R7 low pair");
      step(1'b0, 2'b01, 8'hC3); read_all("R5/R7 low pair again");
      step(1'b0, 2'b10, 8'hD4); read_all("R4/R6 high pair again");
   endtask

   // R10: read stage 4 while stage 1 is being written
   task automatic t_rw_same_cycle;
      logic [7:0] old4;
      old4 = ms[3];
      @(negedge clk);
      op = 2'b10; din = 8'hE5; rsel = 2'b00;
      #1 chk("R10 read during load", y_s, old4);
      @(posedge clk);
      model(1'b0, 2'b10, 8'hE5);
      #1 chk("R10 read after load", y_s, ms[3]);
      rsel = 2'b11;
      #0.5 chk("R10/R8 new stage 1 visible", y_s, 8'hE5);
      @(negedge clk);
      op = 2'b11;
   endtask

   task automatic t_oe;
      @(negedge clk);
      oe_n = 1'b1; rsel = 2'b11;
      #1;
      chk("R9 y zero when disabled", y_s, 8'h00);
      chk("R9 y_en low when disabled", {7'b0, en_s}, 8'h00);
      oe_n = 1'b0;
      #1;
      chk("R9 y_en high when enabled", {7'b0, en_h}, 8'h01);
      chk("R9 data returns", y_h, mh[0]);
   endtask

   initial begin
      #150000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      srst = 1'b1; op = 2'b11; rsel = 2'b00; din = 8'h00; oe_n = 1'b0;
      for (int k = 0; k < 4; k++) begin ms[k] = 8'h00; mh[k] = 8'h00; end
      t_reset();
      t_shift();
      t_freeze();
      t_pairs();
      t_rw_same_cycle();
      t_oe();
      t_reset();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule